// File: doc/BRIEF.md
# Transmit Descriptor DMA Reader

This block walks a ring of transmit descriptors in memory and turns the buffers they point at into a byte stream for a MAC. Each descriptor has two 32-bit words. The buffer address sits at offset +0 and the control/status word at offset +4. Consecutive descriptors are 8 bytes apart, starting at `ring_base`. A start command makes the block fetch descriptors from its current ring position. It reads each buffer a word at a time over a simple request/grant memory port and presents the bytes one per cycle with first-byte, last-byte and CRC-suppress markers.

When a frame is done, the block writes the status back into the control word of the frame's first descriptor. This marks the descriptor as consumed. A frame is cut short in two cases: a consumed descriptor turns up before the frame's last buffer, or the memory starves the byte stream for too long. In either case the block raises an abort pulse on the stream, records the cause in that status, and stops.

A halt request lets the frame in flight finish before the block goes idle. The busy output stays high for as long as the block has work in progress.

Top module: `tdr_dma_reader`

## Requirements
- R1: After reset, `tx_busy`, `tx_valid`, `tx_abort` and `mem_req` are low.
- R2: The descriptor ring is 8-byte aligned. A descriptor's buffer address is read at +0 and its control word at +4, with bits 10:0 of the control word giving the buffer length in bytes. Buffer bytes are streamed one per `tx_valid` cycle, lowest byte of each 32-bit word first, and every memory address issued is word aligned.
- R3: `tx_sof` marks the first byte of a frame and `tx_eof` marks the last byte of the buffer whose control bit 15 is set. A frame may span several descriptors. Both markers appear only with `tx_valid`.
- R4: `tx_nocrc` equals bit 16 of the frame's first descriptor and accompanies every byte of that frame.
- R5: When the descriptor at a frame boundary has bit 31 (consumed) set, the block emits nothing, drops `tx_busy`, and resumes at that same descriptor on the next start.
- R6: After a descriptor whose bit 30 is set, the next fetch is from `ring_base`. Otherwise it is from the following 8-byte slot.
- R7: On normal completion, the control word of the frame's first descriptor is written back with bit 31 set, bits 28 and 27 cleared and all other bits unchanged. The frame's other descriptors are not written.
- R8: If a descriptor with bit 31 set is reached before the last buffer of an open frame, `tx_abort` pulses for one cycle without `tx_valid`. The first descriptor is then written back with bits 31 and 27 set, the block stops, and the next start resumes at the consumed descriptor.
- R9: After a frame's first byte and before its last byte, `STARVE_LIMIT` consecutive cycles without a byte count as an underrun. On an underrun, `tx_abort` pulses, the first descriptor is written back with bits 31 and 28 set, the block stops, and the next start fetches from `ring_base`.
- R10: A halt request lets the current frame finish, including its write-back, and stops the block before the next frame's descriptor is fetched. `tx_busy` stays high until then, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start fetching from the current ring position |
| cmd_halt | input | 1 | Stop after the current frame |
| ring_base | input | AW | Byte address of the descriptor ring, 8-byte aligned |
| tx_busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after the grant |
| tx_valid | output | 1 | Byte present |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_nocrc | output | 1 | Frame must be sent without CRC |
| tx_abort | output | 1 | One-cycle pulse: frame terminated with an error |

## Verification
The underrun path is the hardest to reach from the ports. A correctly fed block never starves, because its worst gap (a buffer change) is shorter than the starvation limit. The bench memory model therefore withholds the grant for reads of one chosen address: the second word of a buffer, after the first four bytes of a frame have already gone out. That holds the stream idle until the limit trips. A following start with a fresh frame at slot 0 then shows that the ring position really returned to the base. The exhausted case is reached the same way, by placing a consumed descriptor directly after a buffer without the last-buffer bit.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
   // control word bit positions (software reads these)
   localparam int CTL_USED  = 31;
   localparam int CTL_WRAP  = 30;
   localparam int CTL_UNDR  = 28;
   localparam int CTL_EXH   = 27;
   localparam int CTL_NOCRC = 16;
   localparam int CTL_LAST  = 15;

   typedef enum logic [3:0] {
      S_IDLE, S_CREQ, S_CWAIT, S_AREQ, S_AWAIT,
      S_DREQ, S_DWAIT, S_EMIT, S_WB
   } tdr_state_e;
endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          wrap,
   input  logic          clr,
   output logic [AW-1:0] off
);
   localparam logic [AW-1:0] STEP = AW'(8);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  off <= '0;
      else if (adv)       off <= wrap ? '0 : off + STEP;
   end
endmodule

// File: rtl/tdr_starve_mon.sv
module tdr_starve_mon #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic sof,
   input  logic eof,
   input  logic abort,
   output logic starve
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST_IDLE = CW'(LIMIT - 1);
   localparam logic [CW-1:0] CAP = CW'(LIMIT);

   logic          open_q;
   logic [CW-1:0] idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         idle_q <= '0;
      end else begin
         if (abort || (valid && eof)) open_q <= 1'b0;
         else if (valid && sof)       open_q <= 1'b1;
         if (!open_q || valid)        idle_q <= '0;
         else if (idle_q != CAP)      idle_q <= idle_q + 1'b1;
      end
   end

   assign starve = open_q && !valid && (idle_q == LAST_IDLE);
endmodule

// File: rtl/tdr_lane.sv
module tdr_lane #(
   parameter int BIG_ENDIAN = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] word_in,
   input  logic [1:0]  idx,
   output logic [7:0]  byte_out
);
   logic [31:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= word_in;
   end

   generate
      if (BIG_ENDIAN != 0) begin : g_be
         assign byte_out = word_q[31 - 8*idx -: 8];
      end else begin : g_le
         assign byte_out = word_q[8*idx +: 8];
      end
   endgenerate
endmodule

// File: rtl/tdr_dma_reader.sv
module tdr_dma_reader
   import tdr_pkg::*;
#(
   parameter int AW           = 16,
   parameter int LEN_W        = 11,
   parameter int STARVE_LIMIT = 8,
   parameter int BIG_ENDIAN   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_halt,
   input  logic [AW-1:0] ring_base,
   output logic          tx_busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_sof,
   output logic          tx_eof,
   output logic          tx_nocrc,
   output logic          tx_abort
);
   localparam logic [AW-1:0]    CTL_OFS = AW'(4);
   localparam logic [AW-1:0]    WSTEP   = AW'(4);
   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

   // elaboration checks
   if (AW < 6) begin : g_bad_aw
      $error("AW must be at least 6");
   end
   if (LEN_W < 1 || LEN_W > CTL_LAST) begin : g_bad_len
      $error("LEN_W must fit below the last-buffer bit");
   end
   if (STARVE_LIMIT < 7) begin : g_bad_lim
      $error("STARVE_LIMIT must exceed the 6-cycle buffer change gap");
   end

   tdr_state_e       state;
   logic [31:0]      first_ctrl;
   logic [AW-1:0]    first_off;
   logic [AW-1:0]    buf_addr;
   logic [AW-1:0]    desc_off;
   logic [LEN_W-1:0] cur_len, remain;
   logic             cur_last, cur_wrap;
   logic             mid, sof_pend, halt_pend;
   logic             err_unr, err_exh, abort_q;
   logic [1:0]       idx;
   logic             starve;

   logic busy_work, unr_ev, exh_ev, halt_stop, endbuf_ev;

   always_comb begin
      busy_work = (state != S_IDLE) && (state != S_WB);
      unr_ev    = busy_work && starve;
      halt_stop = (state == S_CREQ) && !mid && halt_pend;
      exh_ev    = (state == S_CWAIT) && !unr_ev && mem_rdata[CTL_USED] && mid;
      endbuf_ev = !unr_ev && (((state == S_AWAIT) && (cur_len == '0)) ||
                              ((state == S_EMIT) && (remain == ONE)));
   end

   tdr_ring_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(endbuf_ev), .wrap(cur_wrap),
      .clr(unr_ev), .off(desc_off)
   );

   tdr_starve_mon #(.LIMIT(STARVE_LIMIT)) u_starve (
      .clk(clk), .rst_n(rst_n), .valid(tx_valid), .sof(tx_sof),
      .eof(tx_eof), .abort(tx_abort), .starve(starve)
   );

   tdr_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(state == S_DWAIT),
      .word_in(mem_rdata), .idx(idx), .byte_out(tx_data)
   );

   // memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = {1'b1, first_ctrl[30:29], err_unr, err_exh, first_ctrl[26:0]};
      unique case (state)
         S_CREQ: begin
            mem_req  = !halt_stop;
            mem_addr = ring_base + desc_off + CTL_OFS;
         end
         S_AREQ: begin
            mem_req  = 1'b1;
            mem_addr = ring_base + desc_off;
         end
         S_DREQ: begin
            mem_req  = 1'b1;
            mem_addr = buf_addr;
         end
         S_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = ring_base + first_off + CTL_OFS;
         end
         default: ;
      endcase
   end

   assign tx_busy  = (state != S_IDLE);
   assign tx_valid = (state == S_EMIT);
   assign tx_sof   = tx_valid && sof_pend;
   assign tx_eof   = tx_valid && (remain == ONE) && cur_last;
   assign tx_nocrc = tx_valid && first_ctrl[CTL_NOCRC];
   assign tx_abort = abort_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         first_ctrl <= '0;
         first_off  <= '0;
         buf_addr   <= '0;
         cur_len    <= '0;
         remain     <= '0;
         cur_last   <= 1'b0;
         cur_wrap   <= 1'b0;
         mid        <= 1'b0;
         sof_pend   <= 1'b0;
         halt_pend  <= 1'b0;
         err_unr    <= 1'b0;
         err_exh    <= 1'b0;
         abort_q    <= 1'b0;
         idx        <= '0;
      end else begin
         abort_q <= unr_ev || exh_ev;
         if (state == S_IDLE) halt_pend <= 1'b0;
         else if (cmd_halt)   halt_pend <= 1'b1;

         if (unr_ev) begin
            err_unr <= 1'b1;
            state   <= S_WB;
         end else begin
            unique case (state)
               S_IDLE: if (cmd_start) state <= S_CREQ;
               S_CREQ: begin
                  if (halt_stop)    state <= S_IDLE;
                  else if (mem_gnt) state <= S_CWAIT;
               end
               S_CWAIT: begin
                  if (mem_rdata[CTL_USED]) begin
                     if (mid) begin
                        err_exh <= 1'b1;
                        state   <= S_WB;
                     end else begin
                        state   <= S_IDLE;
                     end
                  end else begin
                     cur_len  <= mem_rdata[LEN_W-1:0];
                     cur_last <= mem_rdata[CTL_LAST];
                     cur_wrap <= mem_rdata[CTL_WRAP];
                     if (!mid) begin
                        first_ctrl <= mem_rdata;
                        first_off  <= desc_off;
                        mid        <= 1'b1;
                        sof_pend   <= 1'b1;
                     end
                     state <= S_AREQ;
                  end
               end
               S_AREQ: if (mem_gnt) state <= S_AWAIT;
               S_AWAIT: begin
                  buf_addr <= {mem_rdata[AW-1:2], 2'b00};
                  remain   <= cur_len;
                  if (cur_len == '0) state <= cur_last ? S_WB : S_CREQ;
                  else               state <= S_DREQ;
               end
               S_DREQ: begin
                  if (mem_gnt) begin
                     buf_addr <= buf_addr + WSTEP;
                     state    <= S_DWAIT;
                  end
               end
               S_DWAIT: begin
                  idx   <= '0;
                  state <= S_EMIT;
               end
               S_EMIT: begin
                  sof_pend <= 1'b0;
                  remain   <= remain - ONE;
                  idx      <= idx + 2'd1;
                  if (remain == ONE)   state <= cur_last ? S_WB : S_CREQ;
                  else if (idx == 2'd3) state <= S_DREQ;
               end
               S_WB: begin
                  if (mem_gnt) begin
                     mid     <= 1'b0;
                     err_unr <= 1'b0;
                     err_exh <= 1'b0;
                     state   <= (err_unr || err_exh) ? S_IDLE : S_CREQ;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/tdr_dma_reader_chk.sv
module tdr_dma_reader_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          tx_valid,
   input logic          tx_sof,
   input logic          tx_eof,
   input logic          tx_nocrc,
   input logic          tx_abort
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> !(mem_req || tx_valid));
   // R2
   word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));
   // R3
   marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof || tx_eof || tx_nocrc) |-> tx_valid);
   // R7
   wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[31]);
   // R7
   wb_one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> $countones(mem_wdata[28:27]) <= 1);
   // R8
   abort_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid, tx_abort}));
   // R9
   abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);
endmodule

bind tdr_dma_reader tdr_dma_reader_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
   .tx_nocrc(tx_nocrc), .tx_abort(tx_abort)
);

// File: tb/tb_tdr_dma_reader.sv
module tb_tdr_dma_reader;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0, cmd_halt = 1'b0;
   logic [AW-1:0] ring_base = '0;
   logic          tx_busy, mem_req, mem_we, mem_gnt;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          tx_valid, tx_sof, tx_eof, tx_nocrc, tx_abort;
   logic [7:0]    tx_data;

   int checks = 0, fails = 0;
   bit done = 0;

   // bench memory: 256 words
   logic [31:0] mem [0:255];
   logic        bwe = 1'b0;
   logic [9:0]  baddr = '0;
   logic [31:0] bdat = '0;
   logic        stall_en = 1'b0;
   logic [AW-1:0] stall_addr = '0;

   // expected stream items {abort, sof, eof, nocrc, data}
   logic [11:0] expq [$];

   always #2 clk = ~clk;

   tdr_dma_reader #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
      .ring_base(ring_base), .tx_busy(tx_busy), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
      .tx_nocrc(tx_nocrc), .tx_abort(tx_abort)
   );

   assign mem_gnt = !(stall_en && mem_req && !mem_we && mem_addr == stall_addr);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else if (bwe) begin
         mem[baddr[9:2]] <= bdat;
      end else if (mem_req && mem_gnt) begin
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:2]];
      end
   end

   function automatic logic [7:0] byte_at(input int a);
      return 8'(a * 13 + 5);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic mw(input int a, input logic [31:0] d);
      @(negedge clk);
      bwe = 1'b1; baddr = 10'(a); bdat = d;
      @(negedge clk);
      bwe = 1'b0;
   endtask

   task automatic set_desc(input int slot, input int addr, input logic [31:0] ctl);
      mw(slot * 8, 32'(addr));
      mw(slot * 8 + 4, ctl);
   endtask

   // fill a buffer and queue its bytes
   task automatic add_buf(input int addr, input int len, input bit first,
                          input bit last, input bit nocrc, input int emit);
      for (int w = 0; w < (len + 3) / 4; w++)
         mw(addr + 4 * w, {byte_at(addr + 4*w + 3), byte_at(addr + 4*w + 2),
                           byte_at(addr + 4*w + 1), byte_at(addr + 4*w)});
      for (int k = 0; k < emit; k++)
         expq.push_back({1'b0, first && k == 0, last && k == len - 1, nocrc,
                         byte_at(addr + k)});
   endtask

   task automatic push_abort();
      expq.push_back({1'b1, 3'b000, 8'h00});
   endtask

   task automatic pulse_start();
      @(negedge clk); cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      repeat (2) @(negedge clk);
      while (tx_busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
      check(!tx_busy, req, "busy low at end", 32'(tx_busy), 0);
      check(expq.size() == 0, req, "all expected bytes seen", expq.size(), 0);
   endtask

   task automatic check_ctl(input int slot, input logic [31:0] exp, input string req);
      check(mem[slot * 2 + 1] === exp, req, $sformatf("slot %0d control", slot),
            mem[slot * 2 + 1], exp);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (tx_valid || tx_abort)) begin
         logic [11:0] got, exp;
         got = {tx_abort, tx_sof, tx_eof, tx_nocrc, tx_valid ? tx_data : 8'h00};
         if (expq.size() == 0) begin
            check(1'b0, "R2", "unexpected stream item", 32'(got), 0);
         end else begin
            exp = expq.pop_front();
            check(got === exp, exp[11] ? "R8/R9 abort" : "R2/R3/R4 byte",
                  "stream item", 32'(got), 32'(exp));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!tx_busy, "R1", "busy after reset", 32'(tx_busy), 0);
      check(!tx_valid && !tx_abort, "R1", "stream quiet", {tx_valid, tx_abort}, 0);
      check(!mem_req, "R1", "no memory request", 32'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 consumed descriptor at the boundary: nothing sent
      set_desc(0, 'h200, 32'h8000_0000);
      pulse_start();
      wait_idle("R5");
      check_ctl(0, 32'h8000_0000, "R5");

      // R2 R3 R7 single-buffer frame, resumed at slot 0
      set_desc(0, 'h200, 32'h0000_8006);
      set_desc(1, 'h000, 32'h8000_0000);
      add_buf('h200, 6, 1, 1, 0, 6);
      pulse_start();
      wait_idle("R2");
      check_ctl(0, 32'h8000_8006, "R7");

      // R3 R4 R7 two-buffer frame with CRC suppressed
      set_desc(1, 'h240, 32'h0001_0003);
      set_desc(2, 'h260, 32'h0000_8005);
      set_desc(3, 'h000, 32'h8000_0000);
      add_buf('h240, 3, 1, 0, 1, 3);
      add_buf('h260, 5, 0, 1, 1, 5);
      pulse_start();
      wait_idle("R3");
      check_ctl(1, 32'h8001_0003, "R7");
      check_ctl(2, 32'h0000_8005, "R7 not first");

      // R6 wrap back to ring base
      set_desc(3, 'h280, 32'h4000_8004);
      add_buf('h280, 4, 1, 1, 0, 4);
      pulse_start();
      wait_idle("R6");
      check_ctl(3, 32'hC000_8004, "R6");
      set_desc(0, 'h2A0, 32'h0000_8002);
      add_buf('h2A0, 2, 1, 1, 0, 2);
      pulse_start();
      wait_idle("R6 base");
      check_ctl(0, 32'h8000_8002, "R6");

      // R8 buffers exhausted mid-frame
      set_desc(1, 'h2C0, 32'h0000_0002);
      set_desc(2, 'h000, 32'h8000_0000);
      add_buf('h2C0, 2, 1, 0, 0, 2);
      push_abort();
      pulse_start();
      wait_idle("R8");
      check_ctl(1, 32'h8800_0002, "R8");

      // R9 underrun: second word of the buffer withheld
      set_desc(2, 'h300, 32'h0000_8008);
      add_buf('h300, 8, 1, 1, 0, 4);
      push_abort();
      stall_addr = AW'('h304);
      stall_en = 1'b1;
      pulse_start();
      wait_idle("R9");
      stall_en = 1'b0;
      check_ctl(2, 32'h9000_8008, "R9");
      set_desc(0, 'h320, 32'h0000_8003);
      add_buf('h320, 3, 1, 1, 0, 3);
      pulse_start();
      wait_idle("R9 restart at base");
      check_ctl(0, 32'h8000_8003, "R9");

      // R10 halt during a frame; start while busy ignored
      set_desc(1, 'h340, 32'h0000_8004);
      set_desc(2, 'h360, 32'h0000_8004);
      set_desc(3, 'h000, 32'h8000_0000);
      add_buf('h340, 4, 1, 1, 0, 4);
      mw('h360, {byte_at('h363), byte_at('h362), byte_at('h361), byte_at('h360)});
      pulse_start();
      while (!tx_valid) @(negedge clk);
      cmd_halt = 1'b1;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_halt = 1'b0;
      cmd_start = 1'b0;
      check(tx_busy, "R10", "busy while frame runs", 32'(tx_busy), 1);
      wait_idle("R10");
      check_ctl(1, 32'h8000_8004, "R10");
      check_ctl(2, 32'h0000_8004, "R10 next frame untouched");
      add_buf('h360, 4, 1, 1, 0, 4);
      pulse_start();
      wait_idle("R10 resume");
      check_ctl(2, 32'h8000_8004, "R10");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule